// File: doc/BRIEF.md
# Pixel Stream to Byte Packer

This block sits between a video pixel source and the packet builder of a serial display link. Each clock it can accept one pixel, carried as three 8-bit colour lanes, together with a start-of-frame flag and an end-of-line flag. It turns the pixel into the byte sequence that the link expects for the selected pixel data type, and hands the bytes out one per clock over a valid/ready handshake. On the last byte of each line it also gives the total number of bytes in that line, so the packet builder can fill in the word count of the long packet.

Inside there is a bit accumulator that is filled LSB-first. The formatter reorders and trims the colour lanes into a 16-, 18- or 24-bit word, and the accumulator appends that word at its current fill level. Because of this, the packed 18-bit mode needs no special path even though its pixels straddle byte boundaries. A small state machine tracks line progress. Its states are `ST_IDLE` (no line open), `ST_LINE` (pixels of a line being taken) and `ST_DRAIN` (the end-of-line pixel has been taken and the remaining bytes are being emitted). The transitions are:
- IDLE→LINE when a pixel without end-of-line is accepted.
- IDLE→DRAIN when a single-pixel line is accepted.
- LINE→DRAIN when the end-of-line pixel is accepted.
- DRAIN→IDLE when the last byte leaves.

Top module: `pixel_byte_packer`

## Requirements
- R1: After reset `out_valid` is 0 and `in_ready` is 1. A reset given mid-line discards all pending bytes.
- R2: Data type 0x0E (16-bit 565) emits 2 bytes per pixel, taken from the 16-bit word {B[7:3], G[7:2], R[7:3]} with byte 0 = bits 7:0. The input lanes are R = `in_pix[23:16]`, B = `in_pix[15:8]` and G = `in_pix[7:0]`.
- R3: Data type 0x3E (24-bit) emits the bytes R, G, B in that order.
- R4: Data type 0x2E (18-bit loose) emits 3 bytes R, G, B. Each byte holds the upper 6 bits of its lane left-aligned, with the two low bits 0.
- R5: Data type 0x1E (18-bit packed) appends each pixel's 18-bit word {B[7:2], G[7:2], R[7:2]} to an LSB-first bit stream, so 4 pixels produce exactly 9 bytes.
- R6: Any other data type code passes the pixel through unchanged as 3 bytes: `in_pix[7:0]`, then `[15:8]`, then `[23:16]`.
- R7: At end of line, a partial byte is zero-padded. The final byte carries `out_last`=1, `line_bytes` equals the number of bytes of that line, and no further byte follows.
- R8: `out_sof` is 1 on the first byte of a line whose first pixel had `in_sof`, and 0 on every other byte.
- R9: While `out_valid`=1 and `out_ready`=0, `out_valid` stays 1 and `out_byte` holds its value, and no byte is lost.
- R10: `in_ready` is 0 from the cycle after the end-of-line pixel is accepted until the last byte of that line has been taken.
- R11: The data type is captured on the first pixel of a line. Changes to `in_dtype` later in the same line have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Pixel present |
| in_ready | output | 1 | Pixel will be taken this cycle |
| in_pix | input | 24 | Pixel lanes: R [23:16], B [15:8], G [7:0] |
| in_sof | input | 1 | First pixel of a frame |
| in_eol | input | 1 | Last pixel of a line |
| in_dtype | input | 6 | Pixel data type code |
| out_valid | output | 1 | Byte present |
| out_ready | input | 1 | Byte taken this cycle |
| out_byte | output | 8 | Output byte |
| out_sof | output | 1 | First byte of a frame |
| out_last | output | 1 | Last byte of a line |
| line_bytes | output | 16 | Byte count of the line, valid with out_last |

## Verification
The hardest corner is the packed 18-bit mode. A four-pixel line checks that bits carry across byte boundaries. Single-pixel lines check the zero padding; a design that dropped the partial byte would give 2 bytes, and one that padded wrongly would show stray bits. Single pixels of the other formats use lane values whose low bits differ, so a design that swapped lanes or forgot to truncate is caught. A stalled output checks that the byte stays stable while input is held off. A data-type change in mid-line would alter the byte count if the type were not captured. A reset mid-line must clear leftover bytes.

// File: rtl/pxb_pkg.sv
`timescale 1ns/1ps
package pxb_pkg;
    localparam int COMP_W = 8;
    localparam int PIX_W  = 3 * COMP_W;

    localparam logic [5:0] DT_RGB565  = 6'h0E;
    localparam logic [5:0] DT_RGB666P = 6'h1E;
    localparam logic [5:0] DT_RGB666L = 6'h2E;
    localparam logic [5:0] DT_RGB888  = 6'h3E;

    typedef enum logic [1:0] {ST_IDLE, ST_LINE, ST_DRAIN} pk_state_e;
    typedef enum logic [2:0] {FMT_565, FMT_666P, FMT_666L, FMT_888, FMT_RAW} fmt_e;

    function automatic fmt_e decode_dtype(input logic [5:0] dt);
        fmt_e f;
        case (dt)
            DT_RGB565:  f = FMT_565;
            DT_RGB666P: f = FMT_666P;
            DT_RGB666L: f = FMT_666L;
            DT_RGB888:  f = FMT_888;
            default:    f = FMT_RAW;
        endcase
        return f;
    endfunction
endpackage

// File: rtl/pxb_format.sv
`timescale 1ns/1ps
module pxb_format
    import pxb_pkg::*;
#(
    parameter int NB_W = $clog2(PIX_W + 1)
) (
    input  logic [PIX_W-1:0] pix,
    input  fmt_e             fmt,
    output logic [PIX_W-1:0] word,
    output logic [NB_W-1:0]  nbits
);
    logic [COMP_W-1:0] lane_r, lane_g, lane_b;

    always_comb begin
        lane_r = pix[3*COMP_W-1:2*COMP_W];
        lane_b = pix[2*COMP_W-1:COMP_W];
        lane_g = pix[COMP_W-1:0];
        word   = pix;
        nbits  = NB_W'(PIX_W);
        unique case (fmt)
            FMT_565: begin
                word  = {8'h00, lane_b[7:3], lane_g[7:2], lane_r[7:3]};
                nbits = NB_W'(16);
            end
            FMT_666P: begin
                word  = {6'h00, lane_b[7:2], lane_g[7:2], lane_r[7:2]};
                nbits = NB_W'(18);
            end
            FMT_666L: begin
                word  = {lane_b[7:2], 2'b00, lane_g[7:2], 2'b00, lane_r[7:2], 2'b00};
                nbits = NB_W'(24);
            end
            FMT_888: begin
                word  = {lane_b, lane_g, lane_r};
                nbits = NB_W'(24);
            end
            FMT_RAW: begin
                word  = pix;
                nbits = NB_W'(24);
            end
        endcase
    end

    always_comb begin
        a_r5_width_legal: assert (nbits == NB_W'(16) || nbits == NB_W'(18) || nbits == NB_W'(24));
    end
endmodule

// File: rtl/pxb_bitbuf.sv
`timescale 1ns/1ps
module pxb_bitbuf
    import pxb_pkg::*;
#(
    parameter int BUF_PIX = 2,
    parameter int NB_W    = $clog2(PIX_W + 1),
    localparam int BUF_W  = BUF_PIX * PIX_W,
    localparam int CNT_W  = $clog2(BUF_W + 8)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic [PIX_W-1:0] word,
    input  logic [NB_W-1:0]  nbits,
    input  logic             pad,
    input  logic             pop,
    output logic [7:0]       head,
    output logic [CNT_W-1:0] fill
);
    logic [BUF_W-1:0] buf_q, buf_n, shifted, incoming;
    logic [CNT_W-1:0] cnt_q, cnt_n, cnt_pop, cnt_sum, pad_sum;

    always_comb begin
        shifted  = pop ? (buf_q >> 8) : buf_q;
        cnt_pop  = pop ? (cnt_q - CNT_W'(8)) : cnt_q;
        incoming = {{(BUF_W-PIX_W){1'b0}}, word} << cnt_pop;
        cnt_sum  = cnt_pop + CNT_W'(nbits);
        pad_sum  = cnt_sum + CNT_W'(7);
        buf_n    = shifted;
        cnt_n    = cnt_pop;
        if (push) begin
            buf_n = shifted | incoming;
            cnt_n = pad ? {pad_sum[CNT_W-1:3], 3'b000} : cnt_sum;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            buf_q <= '0;
            cnt_q <= '0;
        end else begin
            buf_q <= buf_n;
            cnt_q <= cnt_n;
        end
    end

    assign head = buf_q[7:0];
    assign fill = cnt_q;

    a_r9_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CNT_W'(BUF_W));
    a_r9_pop_legal: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> cnt_q >= CNT_W'(8));
endmodule

// File: rtl/pixel_byte_packer.sv
`timescale 1ns/1ps
module pixel_byte_packer
    import pxb_pkg::*;
#(
    parameter int BUF_PIX = 2,
    parameter int LCNT_W  = 16,
    localparam int BUF_W  = BUF_PIX * PIX_W,
    localparam int CNT_W  = $clog2(BUF_W + 8),
    localparam int NB_W   = $clog2(PIX_W + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [PIX_W-1:0]  in_pix,
    input  logic              in_sof,
    input  logic              in_eol,
    input  logic [5:0]        in_dtype,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [7:0]        out_byte,
    output logic              out_sof,
    output logic              out_last,
    output logic [LCNT_W-1:0] line_bytes
);
    pk_state_e         state_q, state_n;
    fmt_e              fmt_q, fmt_cur;
    logic              take, fire, sof_q;
    logic [PIX_W-1:0]  word;
    logic [NB_W-1:0]   nbits;
    logic [CNT_W-1:0]  fill;
    logic [LCNT_W-1:0] lcnt_q;

    pxb_format #(.NB_W(NB_W)) u_format (
        .pix   (in_pix),
        .fmt   (fmt_cur),
        .word  (word),
        .nbits (nbits)
    );

    pxb_bitbuf #(.BUF_PIX(BUF_PIX), .NB_W(NB_W)) u_bitbuf (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (take),
        .word  (word),
        .nbits (nbits),
        .pad   (in_eol),
        .pop   (fire),
        .head  (out_byte),
        .fill  (fill)
    );

    // outputs and handshake
    always_comb begin
        fmt_cur    = (state_q == ST_IDLE) ? decode_dtype(in_dtype) : fmt_q;
        in_ready   = (state_q != ST_DRAIN) && (fill <= CNT_W'(BUF_W - PIX_W));
        take       = in_valid && in_ready;
        out_valid  = fill >= CNT_W'(8);
        fire       = out_valid && out_ready;
        out_last   = (state_q == ST_DRAIN) && (fill == CNT_W'(8));
        out_sof    = sof_q && out_valid;
        line_bytes = lcnt_q + LCNT_W'(1);
    end

    // next state
    always_comb begin
        state_n = state_q;
        unique case (state_q)
            ST_IDLE:  if (take) state_n = in_eol ? ST_DRAIN : ST_LINE;
            ST_LINE:  if (take && in_eol) state_n = ST_DRAIN;
            ST_DRAIN: if (fire && out_last) state_n = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_n;
    end

    // line context
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fmt_q  <= FMT_RAW;
            sof_q  <= 1'b0;
            lcnt_q <= '0;
        end else begin
            if (take && state_q == ST_IDLE) fmt_q <= fmt_cur;
            if (take && in_sof && state_q == ST_IDLE) sof_q <= 1'b1;
            else if (fire) sof_q <= 1'b0;
            if (fire) lcnt_q <= out_last ? '0 : lcnt_q + LCNT_W'(1);
        end
    end

    a_r9_hold_byte: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |=> out_valid && $stable(out_byte));
    a_r10_drain_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        state_q == ST_DRAIN |-> !in_ready);
    a_r7_drain_aligned: assert property (@(posedge clk) disable iff (!rst_n)
        state_q == ST_DRAIN |-> fill[2:0] == 3'b000);
    a_r7_count_min: assert property (@(posedge clk) disable iff (!rst_n)
        out_last |-> line_bytes >= LCNT_W'(2));
    a_r11_type_held: assert property (@(posedge clk) disable iff (!rst_n)
        state_q == ST_LINE && state_n == ST_LINE |=> $stable(fmt_q));
endmodule

// File: tb/tb_pixel_byte_packer.sv
`timescale 1ns/1ps
module tb_pixel_byte_packer;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0, in_sof = 1'b0, in_eol = 1'b0, out_ready = 1'b1;
    logic [23:0] in_pix = '0;
    logic [5:0]  in_dtype = '0;
    logic        in_ready, out_valid, out_sof, out_last;
    logic [7:0]  out_byte;
    logic [15:0] line_bytes;

    int checks = 0, errors = 0;

    always #2.5 clk = ~clk;

    pixel_byte_packer dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_pix(in_pix), .in_sof(in_sof), .in_eol(in_eol), .in_dtype(in_dtype),
        .out_valid(out_valid), .out_ready(out_ready), .out_byte(out_byte),
        .out_sof(out_sof), .out_last(out_last), .line_bytes(line_bytes)
    );

    logic [7:0]  got_b   [0:255];
    logic        got_l   [0:255];
    logic        got_s   [0:255];
    logic [15:0] got_n   [0:255];
    int          n_got = 0;
    logic [7:0]  exp_b   [0:15];

    always @(negedge clk) begin
        if (rst_n && out_valid && out_ready) begin
            got_b[n_got[7:0]] <= out_byte;
            got_l[n_got[7:0]] <= out_last;
            got_s[n_got[7:0]] <= out_sof;
            got_n[n_got[7:0]] <= line_bytes;
            n_got <= n_got + 1;
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, expv);
        end
    endtask

    task automatic send(input logic [5:0] dt, input logic [23:0] pix, input bit sof, input bit eol);
        in_valid = 1'b1; in_dtype = dt; in_pix = pix; in_sof = sof; in_eol = eol;
        @(negedge clk);
        while (!in_ready) @(negedge clk);
        @(posedge clk);
        #1 in_valid = 1'b0; in_sof = 1'b0; in_eol = 1'b0;
    endtask

    task automatic check_line(input int start, input int n, input string req, input bit sof_exp);
        while (n_got < start + n) @(negedge clk);
        repeat (3) @(negedge clk);
        check(n_got == start + n, {req, " R7 byte count"}, n_got - start, n);
        for (int k = 0; k < n; k++) begin
            check(got_b[start + k] == exp_b[k], req, got_b[start + k], exp_b[k]);
            check(got_l[start + k] == (k == n - 1), "R7 last flag", got_l[start + k], k == n - 1);
            check(got_s[start + k] == (sof_exp && k == 0), "R8 sof flag", got_s[start + k], sof_exp && k == 0);
        end
        check(got_n[start + n - 1] == 16'(n), "R7 line_bytes", got_n[start + n - 1], n);
        @(posedge clk); #1;
    endtask

    function automatic string tag_of(input logic [5:0] dt);
        case (dt)
            6'h0E: return "R2";
            6'h3E: return "R3";
            6'h2E: return "R4";
            6'h1E: return "R5";
            default: return "R6";
        endcase
    endfunction

    function automatic logic [17:0] w18(input logic [23:0] p);
        return {p[15:10], p[7:2], p[23:18]};
    endfunction

    localparam int NROW = 6;
    localparam logic [5:0]  T_DT  [NROW] = '{6'h0E, 6'h3E, 6'h2E, 6'h0B, 6'h1E, 6'h1E};
    localparam logic [23:0] T_PIX [NROW] = '{24'hA8C864, 24'h125634, 24'hFC0384, 24'hABCDEF, 24'hFC0000, 24'h00FCFC};
    localparam int          T_N   [NROW] = '{2, 3, 3, 3, 3, 3};
    localparam logic [23:0] T_EXP [NROW] = '{24'h00CB35, 24'h563412, 24'h0084FC, 24'hABCDEF, 24'h00003F, 24'h03FFC0};

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int start;
        logic [71:0] stream;
        repeat (3) @(negedge clk);
        check(in_ready == 1'b1, "R1 in_ready in reset", in_ready, 1);
        check(out_valid == 1'b0, "R1 out_valid in reset", out_valid, 0);
        @(posedge clk); #1 rst_n = 1'b1;
        @(posedge clk); #1;

        // single-pixel lines, one per data type (R2 R3 R4 R5 R6)
        for (int i = 0; i < NROW; i++) begin
            start = n_got;
            for (int k = 0; k < 3; k++) exp_b[k] = T_EXP[i][8*k +: 8];
            send(T_DT[i], T_PIX[i], 1'b0, 1'b1);
            check_line(start, T_N[i], tag_of(T_DT[i]), 1'b0);
        end

        // R5 packed four-pixel line: 9 bytes, with sof (R8)
        start = n_got;
        stream = {w18(24'h840408), w18(24'h0000FC), w18(24'h00FC00), w18(24'hFC0000)};
        for (int k = 0; k < 9; k++) exp_b[k] = stream[8*k +: 8];
        send(6'h1E, 24'hFC0000, 1'b1, 1'b0);
        send(6'h1E, 24'h00FC00, 1'b0, 1'b0);
        send(6'h1E, 24'h0000FC, 1'b0, 1'b0);
        send(6'h1E, 24'h840408, 1'b0, 1'b1);
        check_line(start, 9, "R5 packed line", 1'b1);

        // R11 data type change mid-line ignored
        start = n_got;
        for (int k = 0; k < 6; k++) exp_b[k] = T_EXP[1][8*(k%3) +: 8];
        send(6'h3E, 24'h125634, 1'b0, 1'b0);
        send(6'h0E, 24'h125634, 1'b0, 1'b1);
        check_line(start, 6, "R11 type held", 1'b0);

        // R9 / R10 backpressure with a drained line
        start = n_got;
        out_ready = 1'b0;
        send(6'h3E, 24'h125634, 1'b0, 1'b1);
        for (int c = 0; c < 4; c++) begin
            @(negedge clk);
            check(out_valid == 1'b1, "R9 valid held", out_valid, 1);
            check(out_byte == 8'h12, "R9 byte held", out_byte, 8'h12);
            check(in_ready == 1'b0, "R10 input blocked", in_ready, 0);
        end
        @(posedge clk); #1 out_ready = 1'b1;
        for (int k = 0; k < 3; k++) exp_b[k] = T_EXP[1][8*k +: 8];
        check_line(start, 3, "R9 no loss", 1'b0);
        @(negedge clk);
        check(in_ready == 1'b1, "R10 input reopened", in_ready, 1);

        // R1 reset mid-line drops pending bytes
        @(posedge clk); #1 out_ready = 1'b0;
        send(6'h3E, 24'h112233, 1'b0, 1'b0);
        @(posedge clk); #1 rst_n = 1'b0;
        @(posedge clk); #1 rst_n = 1'b1;
        @(negedge clk);
        check(out_valid == 1'b0, "R1 out_valid after reset", out_valid, 0);
        check(in_ready == 1'b1, "R1 in_ready after reset", in_ready, 1);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule